// File: doc/BRIEF.md
# Two-Wire Serial Byte Engine

This block is the byte datapath of a two-wire serial slave. A front end outside the block finds start and stop conditions and turns the clock line into single-cycle rising and falling strobes. The engine shifts its data register one bit per clock, most significant bit first. In the same step it samples the line, so after a byte the register holds whatever was on the bus. The first byte after a start is an address. Its upper seven bits are compared with a programmable own address, and with the all-zero general-call address when that match is enabled. Bit 0 of the address byte is kept as the transfer direction. The acknowledge bit is handled entirely inside the block: it pulls the line low to acknowledge, and as transmitter it reads the master's acknowledge.

Each finished transfer sets an interrupt flag. This happens after the ninth clock of a matching address or of a data byte. While the flag is set, the engine ignores clock strobes and the data register holds still. A processor uses a small register port to read and write the data and address registers, and writes a 1 to clear the flag and release the next byte. The bus side has no data stream, only strobes, so the block has no valid/ready handshake. Back-pressure is the flag itself: the bus is only served while the flag is clear.

Top module: `twb_byte_engine`

## Requirements
- R1: After reset the data register reads 0xFF, the address register reads 0xFE, the control register reads 0x00, and the line is released.
- R2: Each rising strobe with the flag clear shifts the line value into bit 0 of the data register. After eight rising strobes the register holds the byte, first bit in bit 7.
- R3: As transmitter, the engine drives the next bit on each falling strobe. The first bit is driven when the flag is cleared. A 1 is sent by releasing the line, a 0 by pulling it low. At the end of the byte the data register holds the byte seen on the bus.
- R4: An address byte whose upper seven bits equal bits 7:1 of the address register is a match. A match pulls the line low from the eighth falling strobe to the ninth. On the ninth falling strobe the flag sets and the line is released. Received bit 0 is reported as the read direction.
- R5: Address 0x00 is a match only while bit 0 of the address register is 1. Such a match reports the general-call status.
- R6: A non-matching address gives no acknowledge and no flag. All further clocks are ignored until the next start.
- R7: A processor write to the data register takes effect only while the flag is set. At other times it is ignored.
- R8: While the flag is set, clock strobes have no effect and the data register stays unchanged.
- R9: Register select 0 is data, 1 is address and 2 is control. Control reads as {flag, selected, read, general call, 0000}. Writing control with bit 7 at 1 clears the flag.
- R10: As receiver of data bytes, a selected slave acknowledges each byte. As transmitter, it samples the master's acknowledge on the ninth rising strobe. If that bit is a 1 (no acknowledge), the slave deselects on the ninth falling strobe.
- R11: A start strobe resets the bit count and re-enters the address phase, including in the middle of a byte. A stop strobe deselects the slave and releases the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_stb | input | 1 | Start condition seen (one cycle) |
| stop_stb | input | 1 | Stop condition seen (one cycle) |
| scl_rise | input | 1 | Clock line rising strobe |
| scl_fall | input | 1 | Clock line falling strobe |
| sda_in | input | 1 | Sampled data line |
| sda_pull_low | output | 1 | Pull the data line low |
| irq | output | 1 | Interrupt flag |
| slv_selected | output | 1 | Slave currently addressed |
| slv_read | output | 1 | Direction bit of last matching address |
| gcall_hit | output | 1 | Last match was a general call |
| cpu_sel | input | 2 | Register select |
| cpu_we | input | 1 | Register write enable |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data |

## Verification
The hardest case to reach is the slave-transmitter exit. The engine has to be addressed for reading, load a byte while the flag is set, and drive that byte from the moment the flag clears. Then the master's missing acknowledge must drop it off the bus on the right falling strobe. The stimulus builds this step by step: a matching read address first, then a data write, then a flag clear. The bus bit is checked before every rising strobe, and one byte is ended with a 1 in the acknowledge slot. A restart in the middle of a byte and a general-call address that is disabled are driven in the same run, which checks that ignored clocks leave the state unchanged.

// File: rtl/twb_pkg.sv
package twb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA
  } phase_e;

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam int         CTRL_FLAG_BIT = 7;
endpackage

// File: rtl/twb_data_reg.sv
module twb_data_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          sda_in,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '1;
    else if (cpu_wr)   q <= cpu_wdata;
    else if (shift_en) q <= {q[DW-2:0], sda_in};
  end

  AST_SHIFT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (q[0] == $past(sda_in))) else $error("shift lsb"); // R2
endmodule

// File: rtl/twb_addr_cmp.sv
module twb_addr_cmp #(
  parameter int DW = 8,
  localparam int AW = DW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [AW-1:0] cand,
  output logic [DW-1:0] addr_q,
  output logic          own_hit,
  output logic          gc_hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= {{AW{1'b1}}, 1'b0};
    else if (cpu_wr) addr_q <= cpu_wdata;
  end

  assign own_hit = (cand == addr_q[DW-1:1]);
  assign gc_hit  = addr_q[0] && (cand == '0);
endmodule

// File: rtl/twb_bit_seq.sv
module twb_bit_seq
  import twb_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = $clog2(DW + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_stb,
  input  logic stop_stb,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic sda_in,
  input  logic own_hit,
  input  logic gc_hit,
  input  logic data_msb,
  input  logic flag_clr,
  output logic shift_en,
  output logic flag,
  output logic selected,
  output logic read_dir,
  output logic gcall,
  output logic sda_low
);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);
  localparam logic [CW-1:0] ACK_CNT  = CW'(DW);
  localparam logic [CW-1:0] DONE_CNT = CW'(DW + 1);

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic          flag_q, sel_q, rd_q, gc_q, low_q, nack_q;
  logic          active, tx_data;

  assign active   = !flag_q && (phase_q != PH_IDLE);
  assign tx_data  = (phase_q == PH_DATA) && sel_q && rd_q;
  assign shift_en = active && scl_rise && (cnt_q < ACK_CNT) && !start_stb && !stop_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      flag_q  <= 1'b0;
      sel_q   <= 1'b0;
      rd_q    <= 1'b0;
      gc_q    <= 1'b0;
      low_q   <= 1'b0;
      nack_q  <= 1'b0;
    end else if (stop_stb || start_stb) begin
      phase_q <= stop_stb ? PH_IDLE : PH_ADDR;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
      gc_q    <= 1'b0;
      low_q   <= 1'b0;
      nack_q  <= 1'b0;
    end else if (flag_clr && flag_q) begin
      flag_q <= 1'b0;
      low_q  <= tx_data && !data_msb;
    end else if (active && scl_rise) begin
      if (cnt_q < ACK_CNT) begin
        cnt_q <= cnt_q + 1'b1;
        if (phase_q == PH_ADDR && cnt_q == LAST_BIT) begin
          if (own_hit || gc_hit) begin
            sel_q <= 1'b1;
            rd_q  <= sda_in;
            gc_q  <= gc_hit && !own_hit;
          end else begin
            phase_q <= PH_IDLE;
          end
        end
      end else if (cnt_q == ACK_CNT) begin
        cnt_q <= DONE_CNT;
        if (tx_data && sda_in) nack_q <= 1'b1;
      end
    end else if (active && scl_fall) begin
      if (cnt_q < ACK_CNT) begin
        low_q <= tx_data && !data_msb;
      end else if (cnt_q == ACK_CNT) begin
        low_q <= sel_q && !tx_data;
      end else begin
        low_q  <= 1'b0;
        cnt_q  <= '0;
        flag_q <= 1'b1;
        if (phase_q == PH_ADDR) phase_q <= PH_DATA;
        if (nack_q) begin
          sel_q   <= 1'b0;
          phase_q <= PH_IDLE;
          nack_q  <= 1'b0;
        end
      end
    end
  end

  assign flag     = flag_q;
  assign selected = sel_q;
  assign read_dir = rd_q;
  assign gcall    = gc_q;
  assign sda_low  = low_q;

  AST_FLAG_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(scl_fall)) else $error("flag timing"); // R4
  AST_ACK_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    low_q |-> sel_q) else $error("drive while unselected"); // R10
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DONE_CNT) else $error("count range"); // R11
endmodule

// File: rtl/twb_byte_engine.sv
module twb_byte_engine
  import twb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_stb,
  input  logic          stop_stb,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_in,
  output logic          sda_pull_low,
  output logic          irq,
  output logic          slv_selected,
  output logic          slv_read,
  output logic          gcall_hit,
  input  logic [1:0]    cpu_sel,
  input  logic          cpu_we,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata
);
  logic [DW-1:0] data_q, addr_q, ctrl_rd;
  logic          shift_en, flag, own_hit, gc_hit;
  logic          data_we, addr_we, flag_clr;

  assign data_we  = cpu_we && (cpu_sel == SEL_DATA) && flag;
  assign addr_we  = cpu_we && (cpu_sel == SEL_ADDR);
  assign flag_clr = cpu_we && (cpu_sel == SEL_CTRL) && cpu_wdata[CTRL_FLAG_BIT];

  twb_data_reg #(.DW(DW)) u_data (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sda_in(sda_in),
    .cpu_wr(data_we), .cpu_wdata(cpu_wdata), .q(data_q)
  );

  twb_addr_cmp #(.DW(DW)) u_addr (
    .clk(clk), .rst_n(rst_n), .cpu_wr(addr_we), .cpu_wdata(cpu_wdata),
    .cand(data_q[DW-2:0]), .addr_q(addr_q), .own_hit(own_hit), .gc_hit(gc_hit)
  );

  twb_bit_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_stb(start_stb), .stop_stb(stop_stb),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
    .own_hit(own_hit), .gc_hit(gc_hit), .data_msb(data_q[DW-1]),
    .flag_clr(flag_clr), .shift_en(shift_en), .flag(flag),
    .selected(slv_selected), .read_dir(slv_read), .gcall(gcall_hit),
    .sda_low(sda_pull_low)
  );

  always_comb begin
    ctrl_rd       = '0;
    ctrl_rd[DW-1] = flag;
    ctrl_rd[DW-2] = slv_selected;
    ctrl_rd[DW-3] = slv_read;
    ctrl_rd[DW-4] = gcall_hit;
    case (cpu_sel)
      SEL_DATA: cpu_rdata = data_q;
      SEL_ADDR: cpu_rdata = addr_q;
      SEL_CTRL: cpu_rdata = ctrl_rd;
      default:  cpu_rdata = '0;
    endcase
  end

  assign irq = flag;

  AST_HOLD_WHILE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag) && flag && !$past(data_we)) |-> $stable(data_q)) else $error("data moved"); // R8
  AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_sel == SEL_DATA && !flag && !shift_en) |=> $stable(data_q)) else $error("write leaked"); // R7
endmodule

// File: tb/twb_byte_engine_tb_top.sv
module twb_byte_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_stb = 0, stop_stb = 0, scl_rise = 0, scl_fall = 0;
  logic       sda_m = 1'b1;
  logic       sda_bus;
  logic       sda_pull_low, irq, slv_selected, slv_read, gcall_hit;
  logic [1:0] cpu_sel = 2'd0;
  logic       cpu_we = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;

  int tests = 0;
  int fails = 0;

  typedef struct { bit s; bit r; bit g; } ev_t;
  ev_t exp_q[$];

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull_low;

  twb_byte_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start_stb(start_stb), .stop_stb(stop_stb),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_bus),
    .sda_pull_low(sda_pull_low), .irq(irq), .slv_selected(slv_selected),
    .slv_read(slv_read), .gcall_hit(gcall_hit), .cpu_sel(cpu_sel),
    .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // scoreboard monitor: each rising flag pops one expected status
  logic irq_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n && irq && !irq_d) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected flag", 1, 0);
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        chk({slv_selected, slv_read, gcall_hit} == {e.s, e.r, e.g}, "R9 status at flag",
            {slv_selected, slv_read, gcall_hit}, {e.s, e.r, e.g});
      end
    end
    irq_d = irq;
  end

  task automatic push(input bit s, input bit r, input bit g);
    ev_t e;
    e.s = s; e.r = r; e.g = g;
    exp_q.push_back(e);
  endtask

  task automatic p_rise();  @(negedge clk); scl_rise = 1; @(negedge clk); scl_rise = 0; endtask
  task automatic p_fall();  @(negedge clk); scl_fall = 1; @(negedge clk); scl_fall = 0; endtask
  task automatic p_start(); @(negedge clk); start_stb = 1; @(negedge clk); start_stb = 0; endtask
  task automatic p_stop();  @(negedge clk); stop_stb = 1; @(negedge clk); stop_stb = 0; endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); cpu_sel = s; cpu_we = 1; cpu_wdata = d;
    @(negedge clk); cpu_we = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); cpu_sel = s; #1 d = cpu_rdata;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit ack_exp, input string req);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; p_rise(); p_fall();
    end
    sda_m = 1'b1;
    chk(sda_pull_low == ack_exp, req, sda_pull_low, ack_exp);
    p_rise(); p_fall();
  endtask

  task automatic take_byte(input logic [7:0] b, input bit m_ack, input string req);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1;
      chk(sda_bus == b[i], req, sda_bus, b[i]);
      p_rise(); p_fall();
    end
    sda_m = m_ack ? 1'b0 : 1'b1;
    p_rise(); p_fall();
    sda_m = 1'b1;
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, v); chk(v == 8'hFF, "R1 data reset", v, 8'hFF);
    rd(2'd1, v); chk(v == 8'hFE, "R1 addr reset", v, 8'hFE);
    rd(2'd2, v); chk(v == 8'h00, "R1 ctrl reset", v, 8'h00);
    chk(sda_pull_low == 0, "R1 line released", sda_pull_low, 0);
    // R7 write while flag clear is ignored
    wr(2'd0, 8'h3C); rd(2'd0, v); chk(v == 8'hFF, "R7 ignored write", v, 8'hFF);
    wr(2'd1, 8'hA2); rd(2'd1, v); chk(v == 8'hA2, "R9 addr write", v, 8'hA2);
    // R4 own address, write direction
    p_start(); push(1, 0, 0);
    send_byte(8'hA2, 1'b1, "R4 address ack");
    @(negedge clk); chk(irq == 1, "R4 flag set", irq, 1);
    chk(sda_pull_low == 0, "R4 line released after ninth", sda_pull_low, 0);
    rd(2'd2, v); chk(v == 8'hC0, "R9 ctrl after match", v, 8'hC0);
    // R7 write while flag set accepted; R8 strobes ignored
    wr(2'd0, 8'h11); rd(2'd0, v); chk(v == 8'h11, "R7 write accepted", v, 8'h11);
    sda_m = 1'b0; repeat (3) p_rise(); sda_m = 1'b1;
    rd(2'd0, v); chk(v == 8'h11, "R8 data held", v, 8'h11);
    // R9 clear, R2/R10 receive data with ack
    wr(2'd2, 8'h80); rd(2'd2, v); chk(v[7] == 0, "R9 flag cleared", v[7], 0);
    push(1, 0, 0);
    send_byte(8'h96, 1'b1, "R10 data ack");
    rd(2'd0, v); chk(v == 8'h96, "R2 byte received", v, 8'h96);
    // R5 general call disabled, R6 rest ignored
    wr(2'd2, 8'h80);
    p_start();
    send_byte(8'h00, 1'b0, "R5 gc disabled no ack");
    @(negedge clk); chk(irq == 0, "R5 no flag", irq, 0);
    send_byte(8'h55, 1'b0, "R6 ignored byte no ack");
    chk(irq == 0, "R6 no flag", irq, 0);
    rd(2'd0, v); chk(v == 8'h00, "R6 data untouched", v, 8'h00);
    // R5 general call enabled
    wr(2'd1, 8'hA3);
    p_start(); push(1, 0, 1);
    send_byte(8'h00, 1'b1, "R5 gc ack");
    chk(gcall_hit == 1, "R5 gc status", gcall_hit, 1);
    // R6 mismatch
    wr(2'd2, 8'h80);
    p_start();
    send_byte(8'h44, 1'b0, "R6 mismatch no ack");
    chk(irq == 0 && slv_selected == 0, "R6 not selected", {irq, slv_selected}, 0);
    // R3 slave transmitter, R10 master nack
    p_start(); push(1, 1, 0);
    send_byte(8'hA3, 1'b1, "R4 read address ack");
    chk(slv_read == 1, "R4 read direction", slv_read, 1);
    wr(2'd0, 8'hA5);
    wr(2'd2, 8'h80); push(1, 1, 0);
    take_byte(8'hA5, 1'b1, "R3 tx bit");
    rd(2'd0, v); chk(v == 8'hA5, "R3 data holds bus byte", v, 8'hA5);
    wr(2'd0, 8'h3C);
    wr(2'd2, 8'h80); push(0, 1, 0);
    take_byte(8'h3C, 1'b0, "R3 tx bit 2");
    chk(slv_selected == 0, "R10 nack deselects", slv_selected, 0);
    wr(2'd2, 8'h80);
    chk(sda_pull_low == 0, "R10 released after nack", sda_pull_low, 0);
    // R11 restart mid byte
    p_start();
    sda_m = 1'b0; repeat (4) begin p_rise(); p_fall(); end
    p_start(); push(1, 0, 0);
    send_byte(8'hA2, 1'b1, "R11 restart realigns");
    chk(irq == 1, "R11 flag after restart", irq, 1);
    p_stop();
    chk(slv_selected == 0 && sda_pull_low == 0, "R11 stop deselects", {slv_selected, sda_pull_low}, 0);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all flags seen", exp_q.size(), 0);
    summary();
  end
endmodule